// File: doc/BRIEF.md
# Four-State Soft-Decision Viterbi Decoder

This block recovers the data stream from a rate-1/2 convolutional code with constraint length 3 (generators 7 and 5 octal, four trellis states). Each clock where `in_valid_i` is high, it takes one pair of signed 8-bit soft samples. It forms two correlation branch metrics: the sum and the difference of the pair. It then updates the path metrics of all four states with add-compare-select, and the larger metric wins. Survivor histories are 32-bit register-exchange words, one per state.

Path metrics and survivors are kept in two register banks. Each accepted pair reads one bank and writes the other. When the largest new metric grows past a threshold, that maximum is subtracted from every state, so the metrics stay bounded. Once 32 pairs have filled the survivor depth, every further pair produces one hard decision, registered, with a one-cycle valid strobe. The decision is the bit shifted out of the best state's survivor, so the output stream is the source stream delayed by exactly 32 pairs.

Top module: `vit_decoder`

## Requirements
- R1: A positive soft sample stands for code bit 0. For an expected symbol pair (c0,c1), the branch correlation is: 00 gives s0+s1, 11 gives -(s0+s1), 01 gives s0-s1, and 10 gives -(s0-s1).
- R2: Each state keeps the larger of its two candidate metrics. On equal candidates it keeps the lower-numbered predecessor. The best state is the one with the largest new metric, and the lowest index wins a tie.
- R3: After reset, state 0 has metric 0 and states 1 to 3 have metric -768, all survivors are zero and `bit_valid_o`/`bit_o` are 0. Decoding therefore assumes the encoder starts in state 0.
- R4: The trellis uses state index 2*d1+d2, where d1 is the newest past bit. For input u: c0 = u^d1^d2, c1 = u^d2, and the next state is 2*u+d1. Each survivor word is its winning predecessor's word shifted right by one bit, with u entering at the MSB.
- R5: Metrics and survivors live in two banks. Every accepted pair reads one bank and writes the other, and the bank roles swap on that edge.
- R6: The first 32 accepted pairs produce no output. Each later accepted pair raises `bit_valid_o` for exactly one cycle, right after the edge that accepts it.
- R7: The decoded bit is the LSB shifted out of the best state's survivor. On error-free input, the k-th output bit equals source bit k.
- R8: When the largest new metric is 7000 or more, it is subtracted from all four new metrics before they are stored. Metric arithmetic saturates at the 16-bit signed limits, so long strong streams decode without error.
- R9: Isolated sign errors on single soft samples, at least 16 pairs apart, are corrected in the output stream.
- R10: A cycle with `in_valid_i` low changes no state and gives no output. The output sequence with idle gaps is identical to the one without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft0_i | input | 8 | Signed soft sample for code bit c0 |
| soft1_i | input | 8 | Signed soft sample for code bit c1 |
| in_valid_i | input | 1 | Soft pair valid this cycle |
| bit_o | output | 1 | Decoded hard bit |
| bit_valid_o | output | 1 | `bit_o` holds a new decision |

## Verification
A wrong survivor shift, a wrong branch sign or a wrong tie rule can stay hidden inside the register-exchange words for up to 32 pairs. It then appears at `bit_o` as a mismatch against the delayed source, so every stream runs well past that depth. A swapped bank or an off-by-one in the fill counter shows at once as an early, late or missing `bit_valid_o` strobe. Missing renormalization shows only after a few hundred strong pairs, when saturated metrics tie and decisions start to fail. The all-zero input stream makes every comparison a tie, so any wrong tie preference shows up as decoded ones after 32 pairs.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int SOFT_W = 8;
  localparam int BM_W   = SOFT_W + 1;
  localparam int PM_W   = 16;

  typedef logic signed [SOFT_W-1:0] soft_t;
  typedef logic signed [BM_W-1:0]   bm_t;
  typedef logic signed [PM_W-1:0]   pm_t;

  localparam pm_t PM_MAX = {1'b0, {(PM_W-1){1'b1}}};
  localparam pm_t PM_MIN = {1'b1, {(PM_W-1){1'b0}}};

  function automatic pm_t pm_sat_add(input pm_t a, input pm_t b);
    logic signed [PM_W:0] s;
    s = {a[PM_W-1], a} + {b[PM_W-1], b};
    if (s[PM_W] != s[PM_W-1]) return s[PM_W] ? PM_MIN : PM_MAX;
    return s[PM_W-1:0];
  endfunction

  function automatic pm_t pm_sat_sub(input pm_t a, input pm_t b);
    logic signed [PM_W:0] s;
    s = {a[PM_W-1], a} - {b[PM_W-1], b};
    if (s[PM_W] != s[PM_W-1]) return s[PM_W] ? PM_MIN : PM_MAX;
    return s[PM_W-1:0];
  endfunction

  function automatic pm_t bm_ext(input bm_t b);
    return {{(PM_W-BM_W){b[BM_W-1]}}, b};
  endfunction

  function automatic logic parity(input int unsigned g, input int unsigned v);
    return ^(g & v);
  endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu
  import vit_pkg::*;
(
  input  soft_t soft0_i,
  input  soft_t soft1_i,
  output bm_t   sum_o,
  output bm_t   diff_o
);
  assign sum_o  = {soft0_i[SOFT_W-1], soft0_i} + {soft1_i[SOFT_W-1], soft1_i};
  assign diff_o = {soft0_i[SOFT_W-1], soft0_i} - {soft1_i[SOFT_W-1], soft1_i};
endmodule

// File: rtl/vit_acs.sv
module vit_acs
  import vit_pkg::*;
#(
  parameter int          K      = 3,
  parameter int unsigned G0     = 7,
  parameter int unsigned G1     = 5,
  parameter int          SURV_W = 32,
  parameter int          NS     = 0
) (
  input  pm_t               pm_i [1<<(K-1)],
  input  logic [SURV_W-1:0] sv_i [1<<(K-1)],
  input  bm_t               sum_i,
  input  bm_t               diff_i,
  output pm_t               pm_o,
  output logic [SURV_W-1:0] sv_o,
  output logic              drop_o
);
  localparam int SW  = K - 1;
  localparam int NST = 1 << SW;
  localparam int U   = NS >> (SW - 1);
  // predecessors share all state bits but the oldest one
  localparam int PA  = (NS << 1) & (NST - 1);
  localparam int PB  = PA | 1;
  localparam logic A0 = parity(G0, (U << SW) | PA);
  localparam logic A1 = parity(G1, (U << SW) | PA);
  localparam logic B0 = parity(G0, (U << SW) | PB);
  localparam logic B1 = parity(G1, (U << SW) | PB);

  function automatic pm_t corr(input logic c0, input logic c1, input bm_t s, input bm_t d);
    pm_t v;
    v = (c0 == c1) ? bm_ext(s) : bm_ext(d);
    return c0 ? -v : v;
  endfunction

  pm_t  cand_a, cand_b;
  logic take_b;

  assign cand_a = pm_sat_add(pm_i[PA], corr(A0, A1, sum_i, diff_i));
  assign cand_b = pm_sat_add(pm_i[PB], corr(B0, B1, sum_i, diff_i));
  assign take_b = cand_b > cand_a;

  always_comb begin
    if (take_b) begin
      pm_o   = cand_b;
      sv_o   = {1'(U), sv_i[PB][SURV_W-1:1]};
      drop_o = sv_i[PB][0];
    end else begin
      pm_o   = cand_a;
      sv_o   = {1'(U), sv_i[PA][SURV_W-1:1]};
      drop_o = sv_i[PA][0];
    end
  end
endmodule

// File: rtl/vit_best.sv
module vit_best
  import vit_pkg::*;
#(
  parameter int NST = 4,
  localparam int IDX_W = $clog2(NST)
) (
  input  pm_t              pm_i [NST],
  output logic [IDX_W-1:0] idx_o,
  output pm_t              max_o
);
  always_comb begin
    idx_o = '0;
    max_o = pm_i[0];
    for (int i = 1; i < NST; i++) begin
      if (pm_i[i] > max_o) begin
        max_o = pm_i[i];
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vit_decoder.sv
module vit_decoder
  import vit_pkg::*;
#(
  parameter int          K         = 3,
  parameter int unsigned G0        = 7,
  parameter int unsigned G1        = 5,
  parameter int          SURV_W    = 32,
  parameter int          RENORM_TH = 7000,
  parameter int          INIT_PM   = -768
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [SOFT_W-1:0] soft0_i,
  input  logic signed [SOFT_W-1:0] soft1_i,
  input  logic                     in_valid_i,
  output logic                     bit_o,
  output logic                     bit_valid_o
);
  localparam int NST   = 1 << (K - 1);
  localparam int IDX_W = $clog2(NST);
  localparam int CNT_W = $clog2(SURV_W + 1);

  logic              bank_sel;
  pm_t               pm_q [2][NST];
  logic [SURV_W-1:0] sv_q [2][NST];
  logic [CNT_W-1:0]  cnt_q;
  logic              bit_q, valid_q;

  pm_t               pm_rd  [NST];
  logic [SURV_W-1:0] sv_rd  [NST];
  pm_t               pm_new [NST];
  pm_t               pm_wr  [NST];
  logic [SURV_W-1:0] sv_new [NST];
  logic [NST-1:0]    drop;
  bm_t               bm_sum, bm_diff;
  logic [IDX_W-1:0]  best_idx;
  pm_t               best_max;
  logic              renorm;

  always_comb begin
    for (int i = 0; i < NST; i++) begin
      pm_rd[i] = pm_q[bank_sel][i];
      sv_rd[i] = sv_q[bank_sel][i];
    end
  end

  vit_bmu u_bmu (
    .soft0_i (soft0_i),
    .soft1_i (soft1_i),
    .sum_o   (bm_sum),
    .diff_o  (bm_diff)
  );

  for (genvar s = 0; s < NST; s++) begin : g_acs
    vit_acs #(
      .K(K), .G0(G0), .G1(G1), .SURV_W(SURV_W), .NS(s)
    ) u_acs (
      .pm_i   (pm_rd),
      .sv_i   (sv_rd),
      .sum_i  (bm_sum),
      .diff_i (bm_diff),
      .pm_o   (pm_new[s]),
      .sv_o   (sv_new[s]),
      .drop_o (drop[s])
    );
  end

  vit_best #(.NST(NST)) u_best (
    .pm_i  (pm_new),
    .idx_o (best_idx),
    .max_o (best_max)
  );

  assign renorm = best_max >= pm_t'(RENORM_TH);

  always_comb begin
    for (int i = 0; i < NST; i++)
      pm_wr[i] = renorm ? pm_sat_sub(pm_new[i], best_max) : pm_new[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_sel <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= 1'b0;
      valid_q  <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < NST; i++) begin
          pm_q[b][i] <= (i == 0) ? '0 : pm_t'(INIT_PM);
          sv_q[b][i] <= '0;
        end
      end
    end else if (in_valid_i) begin
      for (int i = 0; i < NST; i++) begin
        pm_q[~bank_sel][i] <= pm_wr[i];
        sv_q[~bank_sel][i] <= sv_new[i];
      end
      bank_sel <= ~bank_sel;
      if (cnt_q != CNT_W'(SURV_W)) cnt_q <= cnt_q + 1'b1;
      valid_q <= cnt_q == CNT_W'(SURV_W);
      bit_q   <= drop[best_idx];
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = valid_q;
endmodule

// File: rtl/vit_decoder_chk.sv
module vit_decoder_chk
  import vit_pkg::*;
#(
  parameter int NST       = 4,
  parameter int SURV_W    = 32,
  parameter int RENORM_TH = 7000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic bit_valid_o,
  input logic bank_sel_i,
  input pm_t  pm_rd_i [NST]
);
  int  seen_q;
  pm_t rd_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 0;
    else if (in_valid_i && seen_q <= SURV_W) seen_q <= seen_q + 1;
  end

  always_comb begin
    rd_max = pm_rd_i[0];
    for (int i = 1; i < NST; i++) if (pm_rd_i[i] > rd_max) rd_max = pm_rd_i[i];
  end

  AST_BANK_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> bank_sel_i != $past(bank_sel_i)); // R5
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(bank_sel_i)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !bit_valid_o); // R10
  AST_NO_EARLY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> seen_q > SURV_W); // R6
  AST_OUT_EACH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && seen_q >= SURV_W) |=> bit_valid_o); // R6
  AST_METRIC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> rd_max < pm_t'(RENORM_TH)); // R8
endmodule

bind vit_decoder vit_decoder_chk #(
  .NST(NST), .SURV_W(SURV_W), .RENORM_TH(RENORM_TH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .bit_valid_o (bit_valid_o),
  .bank_sel_i  (bank_sel),
  .pm_rd_i     (pm_rd)
);

// File: tb/vit_decoder_bench.sv
module vit_decoder_bench;
  localparam int DEPTH = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [7:0] soft0_i = '0, soft1_i = '0;
  logic in_valid_i = 1'b0;
  logic bit_o, bit_valid_o;

  int n_chk = 0, n_err = 0;
  logic src [0:511];

  always #5 clk_i = ~clk_i;

  vit_decoder u_vit_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft0_i(soft0_i), .soft1_i(soft1_i),
    .in_valid_i(in_valid_i), .bit_o(bit_o), .bit_valid_o(bit_valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid_i = 1'b0;
    soft0_i = '0;
    soft1_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // encodes src[0..n-1] with g=7,5, drives soft pairs, compares outputs to src
  task automatic run_stream(input int n, input int pos, input int neg,
                            input int flip_every, input int gap_every,
                            output int n_out, output int n_bad,
                            output int first_pair, output int stray);
    logic d1 = 0, d2 = 0, c0, c1, u;
    int p = 0, cyc = 0;
    bit drove = 0;
    n_out = 0; n_bad = 0; first_pair = -1; stray = 0;
    while (1) begin
      @(negedge clk_i);
      if (bit_valid_o) begin
        if (!drove) stray++;
        if (first_pair < 0) first_pair = p - 1;
        if (bit_o !== src[n_out]) n_bad++;
        n_out++;
      end
      if (p == n) begin
        in_valid_i = 1'b0;
        if (!drove) break;
        drove = 0;
      end else if (gap_every > 0 && (cyc % gap_every) == gap_every - 1) begin
        in_valid_i = 1'b0;
        soft0_i = 8'sd99;
        soft1_i = -8'sd99;
        drove = 0;
      end else begin
        u = src[p];
        c0 = u ^ d1 ^ d2;
        c1 = u ^ d2;
        d2 = d1;
        d1 = u;
        soft0_i = c0 ? 8'(neg) : 8'(pos);
        soft1_i = c1 ? 8'(neg) : 8'(pos);
        if (flip_every > 0 && (p % flip_every) == flip_every / 2) soft0_i = -soft0_i;
        in_valid_i = 1'b1;
        drove = 1;
        p++;
      end
      cyc++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(bit_valid_o == 1'b0, "R3", "valid after reset", int'(bit_valid_o), 0);
    chk(bit_o == 1'b0, "R3", "bit after reset", int'(bit_o), 0);
  endtask

  task automatic t_clean();
    int no, nb, fp, st;
    do_reset();
    for (int i = 0; i < 120; i++) src[i] = 1'($urandom_range(0, 1));
    src[0] = 1'b1;
    run_stream(120, 64, -64, 0, 0, no, nb, fp, st);
    chk(nb == 0, "R7", "clean random mismatches (R1 R4)", nb, 0);
    chk(no == 120 - DEPTH, "R6", "clean output count", no, 120 - DEPTH);
    chk(fp == DEPTH, "R6", "first output pair index", fp, DEPTH);
    chk(st == 0, "R6", "outputs without input", st, 0);
  endtask

  task automatic t_ones();
    int no, nb, fp, st;
    do_reset();
    for (int i = 0; i < 70; i++) src[i] = 1'b1;
    run_stream(70, 64, -64, 0, 0, no, nb, fp, st);
    chk(nb == 0, "R4", "all-ones mismatches", nb, 0);
    chk(no == 70 - DEPTH, "R6", "all-ones output count", no, 70 - DEPTH);
  endtask

  task automatic t_ties();
    int no, nb, fp, st;
    do_reset();
    for (int i = 0; i < 48; i++) src[i] = 1'b0;
    run_stream(48, 0, 0, 0, 0, no, nb, fp, st);
    chk(nb == 0, "R2", "zero-input tie decisions", nb, 0);
    chk(no == 48 - DEPTH, "R2", "zero-input output count", no, 48 - DEPTH);
  endtask

  task automatic t_noise();
    int no, nb, fp, st;
    do_reset();
    for (int i = 0; i < 200; i++) src[i] = 1'($urandom_range(0, 1));
    run_stream(200, 64, -64, 16, 0, no, nb, fp, st);
    chk(nb == 0, "R9", "flipped-sample mismatches", nb, 0);
    chk(no == 200 - DEPTH, "R9", "flipped output count", no, 200 - DEPTH);
  endtask

  task automatic t_gaps();
    int no, nb, fp, st;
    do_reset();
    for (int i = 0; i < 100; i++) src[i] = 1'($urandom_range(0, 1));
    run_stream(100, 64, -64, 0, 3, no, nb, fp, st);
    chk(nb == 0, "R10", "gapped mismatches (R5)", nb, 0);
    chk(no == 100 - DEPTH, "R10", "gapped output count", no, 100 - DEPTH);
    chk(st == 0, "R10", "output in idle cycle", st, 0);
    chk(fp == DEPTH, "R5", "gapped first output pair", fp, DEPTH);
  endtask

  task automatic t_long();
    int no, nb, fp, st;
    do_reset();
    for (int i = 0; i < 400; i++) src[i] = 1'($urandom_range(0, 1));
    run_stream(400, 127, -128, 0, 0, no, nb, fp, st);
    chk(nb == 0, "R8", "long strong-stream mismatches", nb, 0);
    chk(no == 400 - DEPTH, "R8", "long output count", no, 400 - DEPTH);
  endtask

  task automatic t_midreset();
    int no, nb, fp, st;
    do_reset();
    for (int i = 0; i < 40; i++) src[i] = 1'($urandom_range(0, 1));
    run_stream(40, 64, -64, 0, 0, no, nb, fp, st);
    do_reset();
    chk(bit_valid_o == 1'b0, "R3", "valid after mid reset", int'(bit_valid_o), 0);
    for (int i = 0; i < 50; i++) src[i] = ~src[i];
    run_stream(50, 64, -64, 0, 0, no, nb, fp, st);
    chk(fp == DEPTH, "R3", "refill after mid reset", fp, DEPTH);
    chk(nb == 0, "R3", "decode after mid reset", nb, 0);
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_clean();
    t_ones();
    t_ties();
    t_noise();
    t_gaps();
    t_long();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule